// File: doc/BRIEF.md
# Predicated Element Loop Sequencer

This block expands a single scalar integer add into a hardware loop over a run of registers in a 32-entry, 64-bit integer register file. The caller gives three base register numbers (one destination, two sources), a flag for each one saying whether it is a vector (steps one register per element) or a scalar (stays on its base register), an element count, and a predicate mask. While the loop runs, the block computes one sum per clock cycle, reading both sources through combinational read ports and writing the result through the synchronous write port.

A context register always shows the index of the element that is executing now. A halt request stops the loop before the current element is written and leaves that index in the context register. A later start with the resume flag set continues from that index. When the loop finishes normally, or a start has nothing to do, the context register goes back to zero and `done` pulses for one cycle. A destination flagged scalar limits the loop to a single iteration. While the sequencer is idle, a load port and a peek port give access to the register file, so it can be set up and its results read back.

Top module: `elem_loop_seq`

## Requirements
- R1: After synchronous reset, `busy` is 0, `done` is 0 and `ctx_offs` is 0.
- R2: With all three operands flagged vector and every predicate bit set, a start accepted with count N>0 writes reg[(d+j) mod 32] = reg[(a+j) mod 32] + reg[(b+j) mod 32] (64-bit, wrapping) for j = 0..N-1, one element per cycle. `busy` is high for exactly N cycles after the accepting edge, and `done` is high for exactly one cycle after that.
- R3: A source flagged scalar reads its base register on every element, including when both sources are scalar and the destination is vector.
- R4: Element i writes only when bit i of `pmask` is 1. A masked element still takes a cycle and still advances every vector offset.
- R5: With the destination flagged scalar, the loop runs exactly one iteration, on the starting element, and writes only the destination base register. If that element's predicate bit is 0, nothing is written, and the loop still ends after that single cycle.
- R6: While `busy` is high, `ctx_offs` equals the index of the element executing in that cycle. It is 0 after the loop ends normally.
- R7: A start with `vlen` = 0 makes `done` high on the next cycle. `busy` stays 0, no register is written, and `ctx_offs` is 0.
- R8: When `halt` is high during a busy cycle, the element of that cycle is not written. `busy` falls after that edge, `done` stays 0, and `ctx_offs` keeps that element's index.
- R9: A start with `resume` = 1 begins at element `ctx_offs`, with every vector offset preloaded to that value. If that index is not below `vlen`, the start behaves as in R7 and clears `ctx_offs`.
- R10: All register addresses are formed as base plus offset, modulo 32.
- R11: A start pulse while `busy` is high is ignored. The running loop keeps its operands and its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a loop; sampled only while idle |
| resume | input | 1 | With start: begin at the saved context index instead of 0 |
| halt | input | 1 | Stop a running loop before the current element is written |
| dst_base | input | 5 | Destination base register |
| src_a_base | input | 5 | First source base register |
| src_b_base | input | 5 | Second source base register |
| dst_vec | input | 1 | Destination is a vector (1) or a scalar (0) |
| src_a_vec | input | 1 | First source is a vector (1) or a scalar (0) |
| src_b_vec | input | 1 | Second source is a vector (1) or a scalar (0) |
| vlen | input | 7 | Element count, 0 to 64 |
| pmask | input | 64 | Predicate mask; bit i enables element i |
| busy | output | 1 | Loop in progress |
| done | output | 1 | One-cycle pulse when a loop completes |
| ctx_offs | output | 7 | Saved element context index |
| ld_we | input | 1 | Register file write enable, honoured while idle |
| ld_addr | input | 5 | Register file write address for loading |
| ld_data | input | 64 | Register file write data for loading |
| peek_addr | input | 5 | Register file read address while idle |
| peek_data | output | 64 | Register file read data at peek_addr |

## Verification
The add loop is run with every operand vector, with one scalar source, with both sources scalar, and with a scalar destination. Comparing the whole register file against an expected model after each run separates stepping operands from fixed ones. A sparse predicate shows that masking suppresses only the write and not the offset advance. A run whose bases sit near register 31 shows the modulo-32 wrap, and that later elements read values written earlier in the same loop. A halt in mid-loop followed by a resume, and a resume whose saved index lies beyond the new length, test the saved context. A start issued while busy tests that the running operands are held.

// File: rtl/elq_pkg.sv
package elq_pkg;

    // Default geometry of the register file and the loop
    localparam int ELQ_XLEN   = 64;
    localparam int ELQ_NREG   = 32;
    localparam int ELQ_VLMAX  = 64;

    // Operand lanes handled by the sequencer
    localparam int NUM_OPND   = 3;

    typedef enum logic [1:0] {
        OPND_DST = 2'd0,
        OPND_SA  = 2'd1,
        OPND_SB  = 2'd2
    } opnd_e;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Width needed to hold a count of 0..n
    function automatic int count_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/elq_regfile.sv
module elq_regfile #(
    parameter int XLEN = elq_pkg::ELQ_XLEN,
    parameter int NREG = elq_pkg::ELQ_NREG,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [AW-1:0]   ra_addr,
    output logic [XLEN-1:0] ra_data,
    input  logic [AW-1:0]   rb_addr,
    output logic [XLEN-1:0] rb_data
);

    logic [XLEN-1:0] mem [NREG];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];

endmodule

// File: rtl/elq_offset.sv
module elq_offset #(
    parameter int VLW = 7,
    parameter int AW  = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           load_vec,
    input  logic [VLW-1:0] load_idx,
    input  logic           step,
    input  logic           run_vec,
    input  logic [AW-1:0]  base,
    output logic [VLW-1:0] offs,
    output logic [VLW-1:0] offs_next,
    output logic [AW-1:0]  addr
);

    assign offs_next = run_vec ? offs + VLW'(1) : offs;

    always_ff @(posedge clk) begin
        if (rst) begin
            offs <= '0;
        end else if (load) begin
            offs <= load_vec ? load_idx : '0;
        end else if (step) begin
            offs <= offs_next;
        end
    end

    // Modulo-register-count address
    assign addr = base + AW'(offs);

    // R3
    scalar_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !run_vec) |=> $stable(offs));

endmodule

// File: rtl/elq_seq_ctrl.sv
module elq_seq_ctrl
    import elq_pkg::*;
#(
    parameter int PW  = ELQ_XLEN,
    parameter int VLW = 7
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic                          resume,
    input  logic                          halt,
    input  logic [VLW-1:0]                vl_in,
    input  logic [PW-1:0]                 pred_in,
    input  logic [NUM_OPND-1:0]           vec_in,
    input  logic [NUM_OPND-1:0][VLW-1:0]  offs_next,
    output logic                          busy,
    output logic                          done,
    output logic [VLW-1:0]                ctx,
    output logic                          accept,
    output logic                          load,
    output logic [VLW-1:0]                load_idx,
    output logic                          step,
    output logic                          wr_en,
    output logic [NUM_OPND-1:0]           vec_q
);

    localparam int PIW = $clog2(PW);

    seq_state_e           state;
    logic [VLW-1:0]       elem;
    logic [VLW-1:0]       vl_q;
    logic [PW-1:0]        pred_q;
    logic                 empty;
    logic                 last;
    logic [NUM_OPND-1:0]  hit_end;

    assign busy     = (state == SEQ_RUN);
    assign accept   = (state == SEQ_IDLE) && start;
    assign load_idx = resume ? ctx : '0;
    assign empty    = (vl_in == '0) || (load_idx >= vl_in);
    assign load     = accept && !empty;
    assign step     = busy && !halt;
    assign wr_en    = step && pred_q[elem[PIW-1:0]];

    for (genvar k = 0; k < NUM_OPND; k++) begin : g_end
        assign hit_end[k] = (offs_next[k] == vl_q);
    end

    assign last = !vec_q[OPND_DST] || (|hit_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_IDLE;
            elem   <= '0;
            ctx    <= '0;
            done   <= 1'b0;
            vl_q   <= '0;
            pred_q <= '0;
            vec_q  <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                if (empty) begin
                    done <= 1'b1;
                    ctx  <= '0;
                end else begin
                    state  <= SEQ_RUN;
                    elem   <= load_idx;
                    ctx    <= load_idx;
                    vl_q   <= vl_in;
                    pred_q <= pred_in;
                    vec_q  <= vec_in;
                end
            end else if (busy) begin
                if (halt) begin
                    state <= SEQ_IDLE;
                end else if (last) begin
                    state <= SEQ_IDLE;
                    done  <= 1'b1;
                    ctx   <= '0;
                end else begin
                    elem <= elem + VLW'(1);
                    ctx  <= elem + VLW'(1);
                end
            end
        end
    end

    // R6
    ctx_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(halt)) |-> (ctx == '0 && done));

    // R6
    ctx_track_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (ctx == $past(ctx) + VLW'(1)));

    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && halt) |=> (!busy && !done && $stable(ctx)));

    // R5
    scalar_dst_one_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !vec_q[OPND_DST]) |=> !busy);

    // R7
    empty_start_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && vl_in == '0) |=> (done && !busy && ctx == '0));

endmodule

// File: rtl/elem_loop_seq.sv
module elem_loop_seq
    import elq_pkg::*;
#(
    parameter int XLEN  = ELQ_XLEN,
    parameter int NREG  = ELQ_NREG,
    parameter int VLMAX = ELQ_VLMAX,
    localparam int AW   = $clog2(NREG),
    localparam int VLW  = count_width(VLMAX)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            resume,
    input  logic            halt,
    input  logic [AW-1:0]   dst_base,
    input  logic [AW-1:0]   src_a_base,
    input  logic [AW-1:0]   src_b_base,
    input  logic            dst_vec,
    input  logic            src_a_vec,
    input  logic            src_b_vec,
    input  logic [VLW-1:0]  vlen,
    input  logic [VLMAX-1:0] pmask,
    output logic            busy,
    output logic            done,
    output logic [VLW-1:0]  ctx_offs,
    input  logic            ld_we,
    input  logic [AW-1:0]   ld_addr,
    input  logic [XLEN-1:0] ld_data,
    input  logic [AW-1:0]   peek_addr,
    output logic [XLEN-1:0] peek_data
);

    logic                          accept;
    logic                          load;
    logic [VLW-1:0]                load_idx;
    logic                          step;
    logic                          wr_en;
    logic [NUM_OPND-1:0]           vec_in;
    logic [NUM_OPND-1:0]           vec_q;
    logic [NUM_OPND-1:0][AW-1:0]   base_in;
    logic [NUM_OPND-1:0][AW-1:0]   base_q;
    logic [NUM_OPND-1:0][VLW-1:0]  offs;
    logic [NUM_OPND-1:0][VLW-1:0]  offs_next;
    logic [NUM_OPND-1:0][AW-1:0]   addr;

    logic            rf_we;
    logic [AW-1:0]   rf_waddr;
    logic [XLEN-1:0] rf_wdata;
    logic [AW-1:0]   rf_ra;
    logic [XLEN-1:0] rf_rda;
    logic [XLEN-1:0] rf_rdb;

    assign vec_in[OPND_DST]  = dst_vec;
    assign vec_in[OPND_SA]   = src_a_vec;
    assign vec_in[OPND_SB]   = src_b_vec;
    assign base_in[OPND_DST] = dst_base;
    assign base_in[OPND_SA]  = src_a_base;
    assign base_in[OPND_SB]  = src_b_base;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else if (load) begin
            base_q <= base_in;
        end
    end

    elq_seq_ctrl #(
        .PW  (VLMAX),
        .VLW (VLW)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .resume    (resume),
        .halt      (halt),
        .vl_in     (vlen),
        .pred_in   (pmask),
        .vec_in    (vec_in),
        .offs_next (offs_next),
        .busy      (busy),
        .done      (done),
        .ctx       (ctx_offs),
        .accept    (accept),
        .load      (load),
        .load_idx  (load_idx),
        .step      (step),
        .wr_en     (wr_en),
        .vec_q     (vec_q)
    );

    for (genvar k = 0; k < NUM_OPND; k++) begin : g_opnd
        elq_offset #(
            .VLW (VLW),
            .AW  (AW)
        ) u_offs (
            .clk       (clk),
            .rst       (rst),
            .load      (load),
            .load_vec  (vec_in[k]),
            .load_idx  (load_idx),
            .step      (step),
            .run_vec   (vec_q[k]),
            .base      (base_q[k]),
            .offs      (offs[k]),
            .offs_next (offs_next[k]),
            .addr      (addr[k])
        );
    end

    // Port A serves the first source while running, the peek port while idle
    assign rf_ra    = busy ? addr[OPND_SA] : peek_addr;
    assign rf_we    = busy ? wr_en : ld_we;
    assign rf_waddr = busy ? addr[OPND_DST] : ld_addr;
    assign rf_wdata = busy ? (rf_rda + rf_rdb) : ld_data;

    elq_regfile #(
        .XLEN (XLEN),
        .NREG (NREG)
    ) u_rf (
        .clk     (clk),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .ra_addr (rf_ra),
        .ra_data (rf_rda),
        .rb_addr (addr[OPND_SB]),
        .rb_data (rf_rdb)
    );

    assign peek_data = rf_rda;

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(base_q) && $stable(vec_q)));

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done && ctx_offs == '0));

endmodule

// File: tb/sim_elem_loop_seq.sv
module sim_elem_loop_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        start, resume, halt;
    logic [4:0]  dst_base, src_a_base, src_b_base;
    logic        dst_vec, src_a_vec, src_b_vec;
    logic [6:0]  vlen;
    logic [63:0] pmask;
    logic        busy, done;
    logic [6:0]  ctx_offs;
    logic        ld_we;
    logic [4:0]  ld_addr;
    logic [63:0] ld_data;
    logic [4:0]  peek_addr;
    logic [63:0] peek_data;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [63:0] exp_rf [32];

    always #5 clk = ~clk;

    elem_loop_seq u0 (
        .clk(clk), .rst(rst), .start(start), .resume(resume), .halt(halt),
        .dst_base(dst_base), .src_a_base(src_a_base), .src_b_base(src_b_base),
        .dst_vec(dst_vec), .src_a_vec(src_a_vec), .src_b_vec(src_b_vec),
        .vlen(vlen), .pmask(pmask), .busy(busy), .done(done),
        .ctx_offs(ctx_offs), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_data(ld_data), .peek_addr(peek_addr), .peek_data(peek_data)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compare_rf(input string req);
        int bad = -1;
        logic [63:0] got = '0;
        for (int k = 0; k < 32; k++) begin
            peek_addr = 5'(k);
            #1;
            if (peek_data !== exp_rf[k] && bad < 0) begin
                bad = k;
                got = peek_data;
            end
        end
        if (bad < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, $sformatf("%s reg%0d", req, bad), got, exp_rf[bad]);
    endtask

    // Expected effect of one loop, element by element
    task automatic model_run(input int rd, input int ra, input int rb,
                             input bit vd, input bit va, input bit vb,
                             input int vl, input logic [63:0] pm, input int first);
        int od = vd ? first : 0;
        int oa = va ? first : 0;
        int ob = vb ? first : 0;
        for (int i = first; i < vl; i++) begin
            if (pm[i]) exp_rf[(rd + od) % 32] = exp_rf[(ra + oa) % 32] + exp_rf[(rb + ob) % 32];
            if (!vd) break;
            od += 1;
            if (va) oa += 1;
            if (vb) ob += 1;
            if (od == vl || oa == vl || ob == vl) break;
        end
    endtask

    task automatic issue(input int rd, input int ra, input int rb,
                         input bit vd, input bit va, input bit vb,
                         input int vl, input logic [63:0] pm, input bit res);
        @(negedge clk);
        dst_base = 5'(rd); src_a_base = 5'(ra); src_b_base = 5'(rb);
        dst_vec = vd; src_a_vec = va; src_b_vec = vb;
        vlen = 7'(vl); pmask = pm; resume = res; start = 1'b1;
        @(negedge clk);
        start = 1'b0; resume = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 300) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_op(input string req, input int rd, input int ra, input int rb,
                         input bit vd, input bit va, input bit vb,
                         input int vl, input logic [63:0] pm, input int ncyc);
        int n;
        issue(rd, ra, rb, vd, va, vb, vl, pm, 1'b0);
        wait_idle(n);
        chk(n == ncyc, {req, " busy cycles"}, 64'(n), 64'(ncyc));
        chk(done === 1'b1, {req, " done pulse"}, 64'(done), 1);
        chk(ctx_offs === 7'd0, {req, " R6 context cleared"}, 64'(ctx_offs), 0);
        model_run(rd, ra, rb, vd, va, vb, vl, pm, 0);
        compare_rf({req, " register file"});
        @(negedge clk);
        chk(done === 1'b0, {req, " done one cycle"}, 64'(done), 0);
    endtask

    task automatic t_reset;
        chk(busy === 1'b0, "R1 busy", 64'(busy), 0);
        chk(done === 1'b0, "R1 done", 64'(done), 0);
        chk(ctx_offs === 7'd0, "R1 ctx", 64'(ctx_offs), 0);
    endtask

    task automatic t_fill;
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            exp_rf[k] = {32'(k * 7 + 1), 32'hFFFF_FF00 + 32'(k * 9)};
            ld_we = 1'b1; ld_addr = 5'(k); ld_data = exp_rf[k];
        end
        @(negedge clk);
        ld_we = 1'b0;
        compare_rf("R2 preload");
    endtask

    task automatic t_vvv;      // R2
        do_op("R2 vector all", 16, 0, 8, 1, 1, 1, 8, '1, 8);
    endtask

    task automatic t_one_scalar;   // R3
        do_op("R3 scalar b", 20, 2, 5, 1, 1, 0, 4, '1, 4);
        do_op("R3 scalar a", 12, 6, 1, 1, 0, 1, 3, '1, 3);
    endtask

    task automatic t_two_scalar;   // R3
        do_op("R3 both scalar", 24, 3, 4, 1, 0, 0, 5, '1, 5);
    endtask

    task automatic t_pred;         // R4
        do_op("R4 predicate", 10, 1, 17, 1, 1, 1, 8, 64'hA5, 8);
    endtask

    task automatic t_scalar_dst;   // R5
        do_op("R5 scalar dst", 3, 7, 9, 0, 1, 1, 6, '1, 1);
        do_op("R5 scalar dst masked", 4, 7, 9, 0, 1, 1, 6, 64'hFFFF_FFFE, 1);
    endtask

    task automatic t_vl0;          // R7
        issue(5, 6, 7, 1, 1, 1, 0, '1, 1'b0);
        chk(done === 1'b1 && busy === 1'b0, "R7 done next cycle", {busy, done}, 2'b01);
        chk(ctx_offs === 7'd0, "R7 ctx zero", 64'(ctx_offs), 0);
        compare_rf("R7 no writes");
    endtask

    task automatic halt_at3;       // halt a length-8 loop on element 3
        issue(16, 0, 8, 1, 1, 1, 8, '1, 1'b0);
        repeat (3) @(negedge clk);
        chk(ctx_offs === 7'd3 && busy === 1'b1, "R6 context tracks element", 64'(ctx_offs), 3);
        halt = 1'b1;
        @(negedge clk);
        halt = 1'b0;
        chk(busy === 1'b0 && done === 1'b0, "R8 halted idle no done", {busy, done}, 0);
        chk(ctx_offs === 7'd3, "R8 context kept", 64'(ctx_offs), 3);
        model_run(16, 0, 8, 1, 1, 1, 3, '1, 0);
        compare_rf("R8 halted element not written");
    endtask

    task automatic t_halt_resume;  // R8 R9
        int n;
        halt_at3();
        issue(16, 0, 8, 1, 1, 1, 8, '1, 1'b1);
        wait_idle(n);
        chk(n == 5, "R9 resumed busy cycles", 64'(n), 5);
        chk(done === 1'b1 && ctx_offs === 7'd0, "R9 resumed completes", {done, ctx_offs}, {1'b1, 7'd0});
        model_run(16, 0, 8, 1, 1, 1, 8, '1, 3);
        compare_rf("R9 resumed elements");
    endtask

    task automatic t_resume_past;  // R9
        halt_at3();
        issue(16, 0, 8, 1, 1, 1, 2, '1, 1'b1);
        chk(done === 1'b1 && busy === 1'b0, "R9 resume past length", {busy, done}, 2'b01);
        chk(ctx_offs === 7'd0, "R9 resume past clears ctx", 64'(ctx_offs), 0);
        compare_rf("R9 resume past no writes");
    endtask

    task automatic t_wrap;         // R10
        do_op("R10 wrap", 30, 28, 31, 1, 1, 0, 5, '1, 5);
    endtask

    task automatic t_busy_start;   // R11
        int n;
        issue(8, 20, 24, 1, 1, 1, 6, '1, 1'b0);
        dst_base = 5'd0; src_a_base = 5'd1; src_b_base = 5'd2;
        vlen = 7'd2; dst_vec = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle(n);
        chk(n == 5, "R11 length kept", 64'(n), 5);
        model_run(8, 20, 24, 1, 1, 1, 6, '1, 0);
        compare_rf("R11 operands kept");
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; resume = 1'b0; halt = 1'b0;
        dst_base = '0; src_a_base = '0; src_b_base = '0;
        dst_vec = 1'b0; src_a_vec = 1'b0; src_b_vec = 1'b0;
        vlen = '0; pmask = '0; ld_we = 1'b0; ld_addr = '0; ld_data = '0;
        peek_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fill();
        t_vvv();
        t_one_scalar();
        t_two_scalar();
        t_pred();
        t_scalar_dst();
        t_vl0();
        t_halt_resume();
        t_resume_past();
        t_wrap();
        t_busy_start();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule